// File: doc/BRIEF.md
# Dual-Mode SPI Bit-Clock Divider

This block derives the serial bit clock of an SPI master from the module clock, which is also the only clock the block runs on. A configuration word selects one of two division schemes: a linear even divider, where the half-period is N+1 module-clock cycles, and a power-of-two divider, where the half-period is 2^(M-1) cycles. Alongside the toggling serial clock it gives single-cycle strobes for the leading and trailing edge of every bit period. The shift engine uses these strobes to launch or sample data according to its clock-phase setting.

The transfer engine raises `run` for the length of a burst. While `run` is low the serial clock sits at the idle level given by `cpol`, and the phase counter is held at zero. Every burst therefore begins with a full-length first half-period. Configuration writes that arrive during a burst are parked in a holding register and applied once the burst ends, so the bit period never changes within a burst.

Top module: `spiclk_divgen`

## Requirements
- R1: After reset `sclk` equals `cpol`, both strobes are low, and the active setting is the all-zero word (power-of-two mode, M=0), which gives a half-period of one cycle.
- R2: With configuration bit 12 set (linear mode), each half-period of `sclk` lasts N+1 module-clock cycles, where N is configuration bits 7:0.
- R3: With configuration bit 12 clear (power-of-two mode), each half-period lasts 2^(M-1) module-clock cycles, where M is configuration bits 11:8.
- R4: In power-of-two mode, M=0 behaves exactly like M=1, giving a half-period of one cycle.
- R5: In the cycle after `run` is sampled low, `sclk` equals `cpol` and both strobes are low.
- R6: The first toggle of a burst happens a full half-period after the first edge at which `run` is sampled high, including after a burst that was cut short partway through a half-period.
- R7: `lead_stb` is high for exactly the cycle in which `sclk` moves away from `cpol`. `trail_stb` is high for exactly the cycle in which `sclk` returns to `cpol`. No strobe is raised in any other cycle.
- R8: A write with `run` low takes effect from the next cycle. A write with `run` high leaves the current burst's period unchanged and is applied once `run` is low, with the last write winning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 13 | Configuration word: [7:0] linear N, [11:8] exponent M, [12] linear-mode select |
| run | input | 1 | Burst active, from the transfer engine |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial bit clock |
| lead_stb | output | 1 | High in the cycle `sclk` leaves its idle level |
| trail_stb | output | 1 | High in the cycle `sclk` returns to its idle level |

## Verification
The hardest situation to reach is a configuration write that lands in the middle of a burst. The bench must show that the period already running is untouched and that the new value appears only in the next burst. The burst task can raise `cfg_wr` one cycle after `run` rises. It then keeps timing every edge at the old half-period and runs a second burst that must show the new one. A second awkward case is a burst dropped partway through a half-period and restarted at once; the bench cuts `run` after two cycles and checks that the following first toggle still takes the full count.

// File: rtl/spiclk_pkg.sv
// Package: shared types for the SPI bit-clock divider.
// Assumes: configuration word layout is [NW-1:0] linear N, [NW+MW-1:NW] exponent M,
// [NW+MW] mode select.
package spiclk_pkg;

    typedef enum logic {
        DIV_POW2 = 1'b0,
        DIV_LIN  = 1'b1
    } div_mode_e;

endpackage

// File: rtl/spiclk_cfg_hold.sv
// Module: spiclk_cfg_hold
// Keeps the active divider setting and a holding slot for writes that arrive
// while a burst runs. Assumes busy is the transfer engine's run signal.
module spiclk_cfg_hold #(
    parameter int CFG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             busy,
    output logic [CFG_W-1:0] act_cfg
);

    logic [CFG_W-1:0] pend_cfg;
    logic             pend_vld;

    // Purpose: load writes directly when idle, park them when busy, drain on idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg  <= '0;
            pend_cfg <= '0;
            pend_vld <= 1'b0;
        end else if (!busy) begin
            if (wr_en) begin
                act_cfg <= wr_data;
            end else if (pend_vld) begin
                act_cfg <= pend_cfg;
            end
            pend_vld <= 1'b0;
        end else if (wr_en) begin
            pend_cfg <= wr_data;
            pend_vld <= 1'b1;
        end
    end

endmodule

// File: rtl/spiclk_half_calc.sv
// Module: spiclk_half_calc
// Turns the active configuration word into a half-period length in module
// clocks. Assumes HALF_W is wide enough for both N+1 and 2^(2^MW-2).
module spiclk_half_calc
    import spiclk_pkg::*;
#(
    parameter int NW     = 8,
    parameter int MW     = 4,
    parameter int HALF_W = 16,
    localparam int CFG_W = NW + MW + 1
) (
    input  logic [CFG_W-1:0]  cfg,
    output logic [HALF_W-1:0] half_len
);

    localparam int SEL_BIT = NW + MW;

    div_mode_e         mode;
    logic [NW-1:0]     lin_n;
    logic [MW-1:0]     pow_m;
    logic [MW-1:0]     pow_eff;

    assign mode  = div_mode_e'(cfg[SEL_BIT]);
    assign lin_n = cfg[NW-1:0];
    assign pow_m = cfg[NW+MW-1:NW];

    // Purpose: clamp exponent zero to one, the module clock cannot divide by one.
    always_comb begin
        pow_eff = (pow_m == '0) ? MW'(1) : pow_m;
    end

    // Purpose: select the half-period for the chosen scheme.
    always_comb begin
        if (mode == DIV_LIN) begin
            half_len = HALF_W'(lin_n) + HALF_W'(1);
        end else begin
            half_len = HALF_W'(1) << (pow_eff - MW'(1));
        end
    end

endmodule

// File: rtl/spiclk_phase.sv
// Module: spiclk_phase
// Counts module clocks through each half-period, toggles the serial clock and
// raises the edge strobes. Assumes half_len >= 1 and stable during a burst.
module spiclk_phase #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cpol,
    input  logic [HALF_W-1:0] half_len,
    output logic              sclk,
    output logic              lead_stb,
    output logic              trail_stb
);

    logic [HALF_W-1:0] cnt;
    logic              wrap;

    assign wrap = (cnt == half_len - HALF_W'(1));

    // Purpose: phase counter, cleared whenever no burst is running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end

    // Purpose: serial clock level and edge strobes, registered together.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sclk      <= cpol;
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else if (wrap) begin
            sclk      <= ~sclk;
            lead_stb  <= (sclk == cpol);
            trail_stb <= (sclk != cpol);
        end else begin
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end
    end

endmodule

// File: rtl/spiclk_divgen.sv
// Module: spiclk_divgen (top)
// Dual-mode SPI bit-clock divider: linear divide-by-2(N+1) or divide-by-2^M,
// with leading/trailing edge strobes. Assumes a single module clock and that
// cpol is held stable while run is high.
module spiclk_divgen #(
    parameter int NW = 8,
    parameter int MW = 4,
    localparam int CFG_W = NW + MW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             run,
    input  logic             cpol,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);

    localparam int POW_HALF_W = (1 << MW) - 1;
    localparam int HALF_W     = (POW_HALF_W > NW + 1) ? POW_HALF_W : NW + 1;

    logic [CFG_W-1:0]  act_cfg;
    logic [HALF_W-1:0] half_len;

    spiclk_cfg_hold #(.CFG_W(CFG_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .busy    (run),
        .act_cfg (act_cfg)
    );

    spiclk_half_calc #(.NW(NW), .MW(MW), .HALF_W(HALF_W)) u_calc (
        .cfg      (act_cfg),
        .half_len (half_len)
    );

    spiclk_phase #(.HALF_W(HALF_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cpol      (cpol),
        .half_len  (half_len),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

endmodule

// File: rtl/spiclk_divgen_chk.sv
// Module: spiclk_divgen_chk
// Protocol checks on the divider's ports, bound to every spiclk_divgen.
// Assumes cpol is stable while run is high.
module spiclk_divgen_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic cpol,
    input logic sclk,
    input logic lead_stb,
    input logic trail_stb
);

    // R5: idle level follows cpol, no strobes
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sclk == $past(cpol)) && !lead_stb && !trail_stb);

    // R7: at most one strobe at a time
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    // R7: during a burst a strobe appears exactly when sclk changes
    a_r7_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ((sclk != $past(sclk)) == (lead_stb || trail_stb)));

    // R7: leading strobe leaves idle level, trailing strobe returns to it
    a_r7_lead_dir: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sclk != cpol));
    a_r7_trail_dir: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sclk == cpol));

    // R5: strobes only follow a cycle with run high
    a_r5_strobe_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !lead_stb && !trail_stb);

endmodule

bind spiclk_divgen spiclk_divgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cpol      (cpol),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
);

// File: tb/sim_spiclk_divgen.sv
// Bench: directed scenarios for spiclk_divgen, one task per scenario.
module sim_spiclk_divgen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [12:0] cfg_wdata = '0;
    logic        run = 1'b0;
    logic        cpol = 1'b0;
    logic        sclk, lead_stb, trail_stb;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    spiclk_divgen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .run       (run),
        .cpol      (cpol),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    function automatic logic [12:0] lin_word(input int n);
        return {1'b1, 4'd0, 8'(n)};
    endfunction

    function automatic logic [12:0] pow_word(input int m);
        return {1'b0, 4'(m), 8'd0};
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Write a configuration word while idle; usable from the next burst.
    task automatic write_cfg(input logic [12:0] w);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    // Run a burst of nedge sclk edges; each half-period must be exp_half cycles.
    // Optionally write cfg word mid_w one cycle after run rises.
    task automatic burst(input int exp_half, input int nedge, input string req,
                         input logic do_wr, input logic [12:0] mid_w);
        logic prev;
        int   c;
        int   e;
        run = 1'b1;
        prev = sclk;
        c = 0;
        e = 0;
        while (e < nedge) begin
            @(negedge clk);
            if (do_wr && c == 0 && e == 0) begin
                cfg_wr = 1'b1;
                cfg_wdata = mid_w;
            end else begin
                cfg_wr = 1'b0;
            end
            c++;
            if (sclk != prev) begin
                check(c == exp_half, req, "half-period", c, exp_half);
                if (sclk != cpol)
                    check(lead_stb && !trail_stb, "R7", "lead strobe", int'(lead_stb), 1);
                else
                    check(trail_stb && !lead_stb, "R7", "trail strobe", int'(trail_stb), 1);
                prev = sclk;
                c = 0;
                e++;
            end else if (lead_stb || trail_stb) begin
                check(1'b0, "R7", "stray strobe", 1, 0);
            end
            if (c > exp_half + 2) begin
                check(1'b0, req, "no toggle", c, exp_half);
                e = nedge;
            end
        end
        cfg_wr = 1'b0;
        run = 1'b0;
        @(negedge clk);
        check(sclk == cpol, "R5", "idle level", int'(sclk), int'(cpol));
        check(!lead_stb && !trail_stb, "R5", "idle strobes",
              int'(lead_stb) + int'(trail_stb), 0);
    endtask

    task automatic t_reset;
        check(sclk == 1'b0, "R1", "sclk after reset", int'(sclk), 0);
        check(!lead_stb && !trail_stb, "R1", "strobes after reset",
              int'(lead_stb) + int'(trail_stb), 0);
        burst(1, 4, "R1", 1'b0, '0);
    endtask

    task automatic t_linear;
        write_cfg(lin_word(0));
        burst(1, 4, "R2", 1'b0, '0);
        write_cfg(lin_word(3));
        burst(4, 4, "R2", 1'b0, '0);
        write_cfg(lin_word(255));
        burst(256, 3, "R2", 1'b0, '0);
    endtask

    task automatic t_pow2;
        write_cfg(pow_word(1));
        burst(1, 4, "R3", 1'b0, '0);
        write_cfg(pow_word(3));
        burst(4, 4, "R3", 1'b0, '0);
        write_cfg(pow_word(10));
        burst(512, 2, "R3", 1'b0, '0);
        write_cfg(pow_word(0));
        burst(1, 4, "R4", 1'b0, '0);
    endtask

    task automatic t_select;
        write_cfg({1'b1, 4'd4, 8'd2});
        burst(3, 4, "R2", 1'b0, '0);
        write_cfg({1'b0, 4'd4, 8'd2});
        burst(8, 4, "R3", 1'b0, '0);
    endtask

    task automatic t_cpol_high;
        cpol = 1'b1;
        @(negedge clk);
        check(sclk == 1'b1, "R5", "idle high", int'(sclk), 1);
        write_cfg(lin_word(1));
        burst(2, 4, "R7", 1'b0, '0);
        cpol = 1'b0;
        @(negedge clk);
        check(sclk == 1'b0, "R5", "idle low again", int'(sclk), 0);
    endtask

    task automatic t_restart;
        write_cfg(lin_word(3));
        run = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(sclk == cpol, "R6", "no early toggle", int'(sclk), int'(cpol));
        run = 1'b0;
        @(negedge clk);
        burst(4, 2, "R6", 1'b0, '0);
    endtask

    task automatic t_hold;
        write_cfg(lin_word(1));
        burst(2, 6, "R8", 1'b1, lin_word(4));
        burst(5, 4, "R8", 1'b0, '0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_pow2();
        t_select();
        t_cpol_high();
        t_restart();
        t_hold();
        finish_run();
    end

endmodule